// File: doc/BRIEF.md
# Switchable Constant-Coefficient Complex Multiplier

This block multiplies a signed complex sample by a fixed complex constant. Two constants are wired in, and a request input swaps between them while the block runs. Each of the four partial products comes from a constant multiplier that is specialised to the selected set. The input registers, the product registers, the subtractor, the adder and the output registers are shared by both sets and do not change when the set changes.

A swap is not instantaneous. For a parameterised number of clock cycles, called the swap window, the constant multipliers are treated as undefined. Any product computed in that window is tagged invalid. The tag moves down the pipeline with its data and appears as a low `p_valid` when that result reaches the output. A two-bit status output shows which constant set is settled and in use. Both status bits are low during a window.

Top module: `cplx_coef_mul`

## Requirements
- R1: `p_real` equals `x_real*C_re - x_imag*C_im`, read as 18-bit two's complement. C is the set active when the products were formed. Set A is 15 + j14 and set B is 10 + j12.
- R2: `p_imag` equals `x_real*C_im + x_imag*C_re`, under the same conventions as R1.
- R3: After reset, set A is active and `coef_on` is 2'b01. Bit 0 means set A is active and bit 1 means set B is active.
- R4: When `sw_req` is high and `sw_to` names the inactive set (0 = A, 1 = B), `coef_on` reads 2'b00 for exactly WIN_CYC cycles (default 2). After that, only the bit of the new set is high.
- R5: A `sw_req` raised while a window is in progress is ignored. The window length and the set that becomes active are unchanged by it.
- R6: A `sw_req` whose `sw_to` names the set already active opens no window. `coef_on` and `p_valid` stay as they were.
- R7: A result whose products were registered during a window leaves the block with `p_valid` low. A result whose products were registered outside any window leaves with `p_valid` high.
- R8: With `ce` low, no pipeline stage advances, so `p_real`, `p_imag` and `p_valid` hold their values.
- R9: A sample presented at the inputs appears on the outputs after exactly three rising edges with `ce` high.
- R10: An active-low reset clears all valid flags at once, so `p_valid` is low during reset. It also returns the block to set A and clears the data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Pipeline advance enable |
| x_real | input | 8 | Real part of the sample, signed |
| x_imag | input | 8 | Imaginary part of the sample, signed |
| sw_req | input | 1 | Request to swap the constant set |
| sw_to | input | 1 | Set requested: 0 = A (15+j14), 1 = B (10+j12) |
| p_real | output | 18 | Real part of the product, signed |
| p_imag | output | 18 | Imaginary part of the product, signed |
| p_valid | output | 1 | Result was formed under one settled set |
| coef_on | output | 2 | Settled set status: bit 0 = A, bit 1 = B |

## Verification
The table of samples includes the following cases:
- A pure real unit and a pure imaginary unit. These separate the four partial products from one another and expose any swap between the subtractor and the adder.
- The most negative values on both parts, and mixed extremes. These test sign extension and the full output range.
- A mid-range sample that has known results under both sets. It shows that a swap really changes which constants are used.

A steady stream is fed through a swap to check that exactly the results formed inside the window come out invalid. The same stream also checks that a repeated or redundant request changes nothing.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
   typedef enum logic {
      SET_A = 1'b0,
      SET_B = 1'b1
   } coef_set_e;
endpackage

// File: rtl/cmul_swap_ctrl.sv
module cmul_swap_ctrl
   import cmul_pkg::*;
#(
   parameter int WIN_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_req,
   input  logic       sw_to,
   output logic       busy,
   output coef_set_e  act,
   output logic [1:0] coef_on
);
   localparam int CNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);

   initial begin
      if (WIN_CYC < 1) $error("WIN_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   coef_set_e        tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         act   <= SET_A;
         tgt_q <= SET_A;
      end else if (busy) begin
         if (cnt_q == '0) begin
            busy <= 1'b0;
            act  <= tgt_q;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end else if (sw_req && (coef_set_e'(sw_to) != act)) begin
         busy  <= 1'b1;
         cnt_q <= CNT_W'(WIN_CYC - 1);
         tgt_q <= coef_set_e'(sw_to);
      end
   end

   assign coef_on[0] = !busy && (act == SET_A);
   assign coef_on[1] = !busy && (act == SET_B);

   // R5: the target and window are not disturbed by requests inside a window
   a_r5_window_ignores_req: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy && $stable(tgt_q)) || (!busy && act == $past(tgt_q)));

   // R6: a request for the active set opens no window
   a_r6_same_set_no_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sw_req && sw_to == act) |=> !busy && $stable(act));

   // R4: status is never ambiguous
   a_r4_status_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(coef_on));
endmodule

// File: rtl/cmul_const_mul.sv
module cmul_const_mul #(
   parameter int IN_W  = 8,
   parameter int CW    = 5,
   parameter int PW    = 13,
   parameter int K_A   = 15,
   parameter int K_B   = 10,
   parameter int STYLE = 1
) (
   input  logic signed [IN_W-1:0] x,
   input  logic                   sel,
   output logic signed [PW-1:0]   p
);
   localparam logic signed [PW-1:0] KA = PW'(K_A);
   localparam logic signed [PW-1:0] KB = PW'(K_B);

   initial begin
      if (PW < IN_W + CW) $error("product width too small");
      if (STYLE == 1 && (K_A < 0 || K_B < 0)) $error("shift-add needs non-negative constants");
   end

   logic signed [PW-1:0] xe;
   assign xe = PW'(x);

   generate
      if (STYLE == 0) begin : g_mul
         assign p = sel ? (xe * KB) : (xe * KA);
      end else begin : g_shift_add
         logic signed [PW-1:0] k;
         assign k = sel ? KB : KA;
         always_comb begin
            p = '0;
            for (int b = 0; b < CW - 1; b++) begin
               if (k[b]) p = p + (xe <<< b);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cplx_coef_mul.sv
module cplx_coef_mul
   import cmul_pkg::*;
#(
   parameter int IN_W      = 8,
   parameter int OUT_W     = 18,
   parameter int CW        = 5,
   parameter int COEF_A_RE = 15,
   parameter int COEF_A_IM = 14,
   parameter int COEF_B_RE = 10,
   parameter int COEF_B_IM = 12,
   parameter int WIN_CYC   = 2,
   parameter int MUL_STYLE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [IN_W-1:0]  x_real,
   input  logic [IN_W-1:0]  x_imag,
   input  logic             sw_req,
   input  logic             sw_to,
   output logic [OUT_W-1:0] p_real,
   output logic [OUT_W-1:0] p_imag,
   output logic             p_valid,
   output logic [1:0]       coef_on
);
   localparam int PW   = IN_W + CW;
   localparam int KMAX = (1 << (CW - 1)) - 1;

   initial begin
      if (OUT_W < PW + 1) $error("OUT_W too narrow for the sum");
      if (COEF_A_RE > KMAX || COEF_A_IM > KMAX || COEF_B_RE > KMAX || COEF_B_IM > KMAX)
         $error("constant exceeds CW");
      if (MUL_STYLE != 0 && MUL_STYLE != 1) $error("MUL_STYLE must be 0 or 1");
   end

   logic      busy;
   coef_set_e act;

   cmul_swap_ctrl #(.WIN_CYC(WIN_CYC)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_to(sw_to),
      .busy(busy), .act(act), .coef_on(coef_on)
   );

   // stage 0: input registers
   logic signed [IN_W-1:0] xr_q, xi_q;
   logic                   v0_q, v1_q, v2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xr_q <= '0;
         xi_q <= '0;
         v0_q <= 1'b0;
      end else if (ce) begin
         xr_q <= signed'(x_real);
         xi_q <= signed'(x_imag);
         v0_q <= 1'b1;
      end
   end

   // stage 1: four constant products (0: re*re, 1: im*im, 2: re*im, 3: im*re)
   logic signed [PW-1:0] prod_c [4];
   logic signed [PW-1:0] prod_q [4];

   generate
      for (genvar g = 0; g < 4; g++) begin : g_prod
         localparam bit USE_IM_X = (g == 1) || (g == 3);
         localparam bit USE_IM_K = (g == 1) || (g == 2);
         cmul_const_mul #(
            .IN_W(IN_W), .CW(CW), .PW(PW),
            .K_A(USE_IM_K ? COEF_A_IM : COEF_A_RE),
            .K_B(USE_IM_K ? COEF_B_IM : COEF_B_RE),
            .STYLE(MUL_STYLE)
         ) mul_i (
            .x(USE_IM_X ? xi_q : xr_q),
            .sel(act == SET_B),
            .p(prod_c[g])
         );
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  prod_q[g] <= '0;
            else if (ce) prod_q[g] <= prod_c[g];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  v1_q <= 1'b0;
      else if (ce) v1_q <= v0_q && !busy;
   end

   // stage 2: combine
   logic signed [OUT_W-1:0] re_q, im_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         re_q <= '0;
         im_q <= '0;
         v2_q <= 1'b0;
      end else if (ce) begin
         re_q <= OUT_W'(prod_q[0]) - OUT_W'(prod_q[1]);
         im_q <= OUT_W'(prod_q[2]) + OUT_W'(prod_q[3]);
         v2_q <= v1_q;
      end
   end

   assign p_real  = re_q;
   assign p_imag  = im_q;
   assign p_valid = v2_q;

   // R7: products formed inside a window are tagged invalid
   a_r7_window_marks_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && busy) |=> !v1_q);

   // R7: the tag moves to the output unchanged
   a_r7_tag_travels: assert property (@(posedge clk) disable iff (!rst_n)
      ce |=> (p_valid == $past(v1_q)));

   // R8: frozen pipeline holds its outputs
   a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> $stable(p_real) && $stable(p_imag) && $stable(p_valid));
endmodule

// File: tb/cplx_coef_mul_tb_top.sv
module cplx_coef_mul_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0;
   logic [7:0]  x_real = '0, x_imag = '0;
   logic        sw_req = 1'b0, sw_to = 1'b0;
   logic [17:0] p_real, p_imag;
   logic        p_valid;
   logic [1:0]  coef_on;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   cplx_coef_mul dut_i (
      .clk(clk), .rst_n(rst_n), .ce(ce), .x_real(x_real), .x_imag(x_imag),
      .sw_req(sw_req), .sw_to(sw_to), .p_real(p_real), .p_imag(p_imag),
      .p_valid(p_valid), .coef_on(coef_on)
   );

   localparam int N_VEC = 7;
   // x_real, x_imag, expected real, expected imag under set A (15 + j14)
   localparam int VEC [N_VEC][4] = '{
      '{  15,   16,     1,   450},
      '{   0,    0,     0,     0},
      '{   1,    0,    15,    14},
      '{   0,    1,   -14,    15},
      '{-128, -128,  -128, -3712},
      '{ 127, -128,  3697,  -142},
      '{  -1,  127, -1793,  1891}
   };

   function automatic int m_re(int xr, int xi, int cr, int ci);
      return xr * cr - xi * ci;
   endfunction
   function automatic int m_im(int xr, int xi, int cr, int ci);
      return xr * ci + xi * cr;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_out(string req, int er, int ei, bit ev);
      chk(int'($signed(p_real)) == er, {req, " real"}, int'($signed(p_real)), er);
      chk(int'($signed(p_imag)) == ei, {req, " imag"}, int'($signed(p_imag)), ei);
      chk(p_valid == ev, {req, " valid"}, int'(p_valid), int'(ev));
   endtask

   task automatic drive(int xr, int xi);
      x_real = 8'(xr);
      x_imag = 8'(xi);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hr, hi, hv;
      // R10 / R3: reset state
      #1;
      chk(p_valid == 1'b0, "R10 valid in reset", int'(p_valid), 0);
      chk(coef_on == 2'b01, "R3 status after reset", int'(coef_on), 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      ce = 1'b1;
      repeat (4) @(negedge clk);

      // R1 / R2: vector table under set A
      for (int i = 0; i < N_VEC + 3; i++) begin
         if (i >= 3) chk_out("R1 R2 table", VEC[i-3][2], VEC[i-3][3], 1'b1);
         if (i < N_VEC) drive(VEC[i][0], VEC[i][1]);
         else drive(15, 16);
         @(negedge clk);
      end

      // R4 / R5 / R7: swap to set B with a steady stream of 15 + j16
      drive(15, 16);
      sw_to = 1'b1; sw_req = 1'b1;
      @(negedge clk);                         // after edge k
      sw_req = 1'b1; sw_to = 1'b0;            // R5 request inside window
      chk(coef_on == 2'b00, "R4 window status 1", int'(coef_on), 0);
      chk_out("R7 before window", 1, 450, 1'b1);
      @(negedge clk);                         // after edge k+1
      sw_req = 1'b0;
      chk(coef_on == 2'b00, "R4 window status 2", int'(coef_on), 0);
      chk_out("R7 last set A result", 1, 450, 1'b1);
      @(negedge clk);                         // after edge k+2
      chk(coef_on == 2'b10, "R4 R5 new set B active", int'(coef_on), 2);
      chk(p_valid == 1'b0, "R7 window result 1 invalid", int'(p_valid), 0);
      @(negedge clk);                         // after edge k+3
      chk(p_valid == 1'b0, "R7 window result 2 invalid", int'(p_valid), 0);
      chk(coef_on == 2'b10, "R5 no second window", int'(coef_on), 2);
      @(negedge clk);                         // after edge k+4
      chk_out("R1 R2 set B", m_re(15, 16, 10, 12), m_im(15, 16, 10, 12), 1'b1);
      chk(m_re(15, 16, 10, 12) == -42, "R1 model check", m_re(15, 16, 10, 12), -42);

      // R6: request for the already active set
      sw_req = 1'b1; sw_to = 1'b1;
      @(negedge clk);
      sw_req = 1'b0;
      chk(coef_on == 2'b10, "R6 no window status", int'(coef_on), 2);
      @(negedge clk);
      chk(coef_on == 2'b10, "R6 no window status later", int'(coef_on), 2);
      chk(p_valid == 1'b1, "R6 valid kept", int'(p_valid), 1);
      @(negedge clk);
      chk(p_valid == 1'b1, "R6 valid kept later", int'(p_valid), 1);

      // R1 R2 extremes under set B
      drive(-128, -128);
      repeat (3) @(negedge clk);
      chk_out("R1 R2 set B extreme", m_re(-128, -128, 10, 12), m_im(-128, -128, 10, 12), 1'b1);

      // R9: latency of exactly three enabled edges
      drive(0, 0);
      repeat (3) @(negedge clk);
      drive(1, 0);
      @(negedge clk);
      drive(0, 0);
      @(negedge clk);
      chk_out("R9 not yet at edge 2", 0, 0, 1'b1);
      @(negedge clk);
      chk_out("R9 arrives at edge 3", 10, 12, 1'b1);

      // R8: clock enable low freezes the pipeline
      drive(7, -3);
      repeat (3) @(negedge clk);
      hr = int'($signed(p_real));
      hi = int'($signed(p_imag));
      hv = int'(p_valid);
      ce = 1'b0;
      drive(-50, 99);
      repeat (4) @(negedge clk);
      chk_out("R8 hold", hr, hi, hv[0]);
      ce = 1'b1;
      repeat (3) @(negedge clk);
      chk_out("R8 resume", m_re(-50, 99, 10, 12), m_im(-50, 99, 10, 12), 1'b1);

      // R10: reset in mid-run
      rst_n = 1'b0;
      #1;
      chk(p_valid == 1'b0, "R10 valid cleared", int'(p_valid), 0);
      chk(coef_on == 2'b01, "R10 back to set A", int'(coef_on), 1);
      chk(p_real == '0, "R10 data cleared", int'($signed(p_real)), 0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(15, 16);
      repeat (3) @(negedge clk);
      chk_out("R10 set A after reset", 1, 450, 1'b1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule